// File: doc/BRIEF.md
# Memory-Mapped Chip Select Decoder

This block turns the three most significant address bits of an 8-bit microcontroller bus, together with its active-low code-fetch, data-read and data-write strobes, into the select, output-enable and write-enable lines of four devices: a monitor ROM, a user ROM, an 8K SRAM and a peripheral. The address space is split into eight 8K blocks. Each device decides for itself whether it belongs to code space, to data space or to both. The two ROMs answer only to code fetches. The peripheral shares block 0 with the monitor ROM but answers only to data reads and writes, so the two never collide. The SRAM answers to code fetches as well as to data accesses, so a program can be written into it as data and then run from it as code.

The SRAM's block number is a parameter that takes the place of a board placement jumper. Its default is block 4. Every output is purely combinational and is active low.

Top module: `memmap_select`

## Requirements
- R1: The block number is the unsigned value of `addr_hi` (A15 is bit 2, A13 is bit 0). Outputs follow the inputs within the same evaluation, with no register on the path.
- R2: `mon_sel_n` is low exactly when the block number is 0 and `fetch_n` is low.
- R3: `usr_sel_n` is low exactly when the block number is 1 and `fetch_n` is low.
- R4: `ram_oe_n` is low exactly when the block number equals `RAM_BLK` and at least one of `fetch_n` and `rd_n` is low.
- R5: `ram_we_n` is low exactly when the block number equals `RAM_BLK` and `wr_n` is low.
- R6: `ram_ce_n` is low exactly when the block number equals `RAM_BLK` and at least one of the three strobes is low.
- R7: `per_rd_n` is low exactly when the block number is 0 and `rd_n` is low. `per_wr_n` is low exactly when the block number is 0 and `wr_n` is low. `per_ce_n` is low when either of these two is low. A code fetch alone leaves all three high.
- R8: Neither ROM is ever enabled by a data read or a data write alone. With `fetch_n` high, `mon_sel_n` and `usr_sel_n` stay high.
- R9: When `fetch_n`, `rd_n` and `wr_n` are all high, every output is high.
- R10: Changing `RAM_BLK` moves every SRAM output to the new block, and the SRAM outputs stay high for all other blocks. Valid values are 2 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_hi | input | 3 | Address bits A15..A13 |
| fetch_n | input | 1 | Code-fetch strobe, active low |
| rd_n | input | 1 | Data-read strobe, active low |
| wr_n | input | 1 | Data-write strobe, active low |
| mon_sel_n | output | 1 | Monitor ROM select and output enable |
| usr_sel_n | output | 1 | User ROM select and output enable |
| ram_ce_n | output | 1 | SRAM chip enable |
| ram_oe_n | output | 1 | SRAM output enable (fetch or read) |
| ram_we_n | output | 1 | SRAM write enable |
| per_ce_n | output | 1 | Peripheral chip enable |
| per_rd_n | output | 1 | Peripheral read strobe |
| per_wr_n | output | 1 | Peripheral write strobe |

## Verification
The bench sweeps all eight blocks against all eight combinations of the three strobes, and does this on two instances: one with the SRAM in block 4 and one with it in block 6. The single-strobe patterns show which devices each space reaches. A lone fetch in block 0 must enable only the monitor ROM, while a lone read or write there must reach only the peripheral. The combined-strobe patterns and the all-idle pattern confirm the OR behaviour of the SRAM enable and the all-high idle state. The second instance shows that the SRAM placement really follows the parameter and leaves block 4 empty.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int unsigned ADDR_HI_W = 3;
    localparam int unsigned BLK_CNT   = 1 << ADDR_HI_W;
    localparam int unsigned DEV_CNT   = 4;

    localparam int unsigned MON_BLK = 0;
    localparam int unsigned USR_BLK = 1;
    localparam int unsigned PER_BLK = 0;

    typedef enum int unsigned {
        DEV_MON = 0,
        DEV_USR = 1,
        DEV_RAM = 2,
        DEV_PER = 3
    } dev_e;

    // Active-high view of the bus strobes
    typedef struct packed {
        logic code_rd;
        logic data_rd;
        logic data_wr;
    } bus_req_t;

    // Which kinds of access a device answers to
    typedef struct packed {
        logic on_code_rd;
        logic on_data_rd;
        logic on_data_wr;
    } dev_cfg_t;

    function automatic dev_cfg_t dev_cfg(input int unsigned idx);
        dev_cfg_t c;
        case (idx)
            DEV_MON: c = '{on_code_rd: 1'b1, on_data_rd: 1'b0, on_data_wr: 1'b0};
            DEV_USR: c = '{on_code_rd: 1'b1, on_data_rd: 1'b0, on_data_wr: 1'b0};
            DEV_RAM: c = '{on_code_rd: 1'b1, on_data_rd: 1'b1, on_data_wr: 1'b1};
            default: c = '{on_code_rd: 1'b0, on_data_rd: 1'b1, on_data_wr: 1'b1};
        endcase
        return c;
    endfunction

    function automatic int unsigned dev_block(input int unsigned idx,
                                              input int unsigned ram_blk);
        case (idx)
            DEV_MON: return MON_BLK;
            DEV_USR: return USR_BLK;
            DEV_RAM: return ram_blk;
            default: return PER_BLK;
        endcase
    endfunction

endpackage

// File: rtl/cs_strobe_conv.sv
module cs_strobe_conv (
    input  logic             fetch_n,
    input  logic             rd_n,
    input  logic             wr_n,
    output cs_pkg::bus_req_t req
);
    always_comb begin
        req.code_rd = ~fetch_n;
        req.data_rd = ~rd_n;
        req.data_wr = ~wr_n;
    end
endmodule

// File: rtl/cs_blk_decoder.sv
module cs_blk_decoder #(
    parameter int unsigned SEL_W = cs_pkg::ADDR_HI_W
) (
    input  logic [SEL_W-1:0]        addr_hi,
    output logic [(1 << SEL_W)-1:0] blk_n
);
    localparam int unsigned NBLK = 1 << SEL_W;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign blk_n[b] = (addr_hi != SEL_W'(b));
    end

    always_comb begin
        AST_ONE_BLOCK: assert ($countones(~blk_n) == 1); // R1
    end
endmodule

// File: rtl/cs_dev_gate.sv
module cs_dev_gate #(
    parameter cs_pkg::dev_cfg_t CFG = '0
) (
    input  logic             blk_n,
    input  cs_pkg::bus_req_t req,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n
);
    logic rd_hit;
    logic wr_hit;

    always_comb begin
        rd_hit = (CFG.on_code_rd & req.code_rd) | (CFG.on_data_rd & req.data_rd);
        wr_hit = CFG.on_data_wr & req.data_wr;
        ce_n   = blk_n | ~(rd_hit | wr_hit);
        oe_n   = blk_n | ~rd_hit;
        we_n   = blk_n | ~wr_hit;
    end

    always_comb begin
        if (!oe_n) AST_OE_NEEDS_BLOCK: assert (!blk_n && !ce_n); // R6
        if (!we_n) AST_WE_NEEDS_WRITE: assert (req.data_wr && !ce_n); // R5
    end
endmodule

// File: rtl/memmap_select.sv
module memmap_select #(
    parameter int unsigned RAM_BLK = 4
) (
    input  logic [2:0] addr_hi,
    input  logic       fetch_n,
    input  logic       rd_n,
    input  logic       wr_n,
    output logic       mon_sel_n,
    output logic       usr_sel_n,
    output logic       ram_ce_n,
    output logic       ram_oe_n,
    output logic       ram_we_n,
    output logic       per_ce_n,
    output logic       per_rd_n,
    output logic       per_wr_n
);
    import cs_pkg::*;

    bus_req_t             req;
    logic [BLK_CNT-1:0]   blk_n;
    logic [DEV_CNT-1:0]   dev_ce_n;
    logic [DEV_CNT-1:0]   dev_oe_n;
    logic [DEV_CNT-1:0]   dev_we_n;

    cs_strobe_conv u_conv (
        .fetch_n (fetch_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .req     (req)
    );

    cs_blk_decoder #(.SEL_W(ADDR_HI_W)) u_dec (
        .addr_hi (addr_hi),
        .blk_n   (blk_n)
    );

    for (genvar d = 0; d < DEV_CNT; d++) begin : g_dev
        cs_dev_gate #(.CFG(dev_cfg(d))) u_gate (
            .blk_n (blk_n[dev_block(d, RAM_BLK)]),
            .req   (req),
            .ce_n  (dev_ce_n[d]),
            .oe_n  (dev_oe_n[d]),
            .we_n  (dev_we_n[d])
        );
    end

    assign mon_sel_n = dev_oe_n[DEV_MON];
    assign usr_sel_n = dev_oe_n[DEV_USR];
    assign ram_ce_n  = dev_ce_n[DEV_RAM];
    assign ram_oe_n  = dev_oe_n[DEV_RAM];
    assign ram_we_n  = dev_we_n[DEV_RAM];
    assign per_ce_n  = dev_ce_n[DEV_PER];
    assign per_rd_n  = dev_oe_n[DEV_PER];
    assign per_wr_n  = dev_we_n[DEV_PER];

    always_comb begin
        if (!mon_sel_n) AST_MON_FETCH_ONLY: assert (!fetch_n && addr_hi == 3'd0); // R2
        if (!usr_sel_n) AST_USR_FETCH_ONLY: assert (!fetch_n && addr_hi == 3'd1); // R3
        if (!ram_oe_n)  AST_RAM_OE_STROBE: assert (!fetch_n || !rd_n); // R4
        if (!per_ce_n)  AST_PER_DATA_ONLY: assert (!rd_n || !wr_n); // R7
        AST_ROM_NO_WRITE: assert (dev_we_n[DEV_MON] && dev_we_n[DEV_USR]
                                  && dev_ce_n[DEV_MON] == dev_oe_n[DEV_MON]
                                  && dev_ce_n[DEV_USR] == dev_oe_n[DEV_USR]); // R8
        if (fetch_n && rd_n && wr_n)
            AST_IDLE_HIGH: assert (mon_sel_n && usr_sel_n && ram_ce_n && ram_oe_n
                                   && ram_we_n && per_ce_n && per_rd_n && per_wr_n); // R9
        if (!ram_ce_n)  AST_RAM_PLACED: assert (addr_hi == 3'(RAM_BLK)); // R10
    end
endmodule

// File: tb/test_memmap_select.sv
module test_memmap_select;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [2:0] addr_hi;
    logic       fetch_n, rd_n, wr_n;

    logic a_mon, a_usr, a_rce, a_roe, a_rwe, a_pce, a_prd, a_pwr;
    logic b_mon, b_usr, b_rce, b_roe, b_rwe, b_pce, b_prd, b_pwr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    memmap_select #(.RAM_BLK(4)) i_memmap_select (
        .addr_hi (addr_hi), .fetch_n (fetch_n), .rd_n (rd_n), .wr_n (wr_n),
        .mon_sel_n (a_mon), .usr_sel_n (a_usr),
        .ram_ce_n (a_rce), .ram_oe_n (a_roe), .ram_we_n (a_rwe),
        .per_ce_n (a_pce), .per_rd_n (a_prd), .per_wr_n (a_pwr)
    );

    memmap_select #(.RAM_BLK(6)) i_memmap_select_alt (
        .addr_hi (addr_hi), .fetch_n (fetch_n), .rd_n (rd_n), .wr_n (wr_n),
        .mon_sel_n (b_mon), .usr_sel_n (b_usr),
        .ram_ce_n (b_rce), .ram_oe_n (b_roe), .ram_we_n (b_rwe),
        .per_ce_n (b_pce), .per_rd_n (b_prd), .per_wr_n (b_pwr)
    );

    task automatic check(input string req, input string what,
                         input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s blk=%0d f=%b r=%b w=%b got=%b exp=%b",
                     req, what, addr_hi, fetch_n, rd_n, wr_n, got, exp);
        end
    endtask

    task automatic check_inst(input int ram_blk,
                              input logic mon, input logic usr, input logic rce,
                              input logic roe, input logic rwe, input logic pce,
                              input logic prd, input logic pwr);
        bit f = !fetch_n;
        bit r = !rd_n;
        bit w = !wr_n;
        int blk = int'(addr_hi);
        bit in_ram = (blk == ram_blk);
        check("R2", "mon_sel_n", mon, !(blk == 0 && f));
        check("R3", "usr_sel_n", usr, !(blk == 1 && f));
        check("R4", "ram_oe_n",  roe, !(in_ram && (f || r)));
        check("R5", "ram_we_n",  rwe, !(in_ram && w));
        check("R6", "ram_ce_n",  rce, !(in_ram && (f || r || w)));
        check("R7", "per_ce_n",  pce, !(blk == 0 && (r || w)));
        check("R7", "per_rd_n",  prd, !(blk == 0 && r));
        check("R7", "per_wr_n",  pwr, !(blk == 0 && w));
        if (!f) begin
            check("R8", "mon idle w/o fetch", mon, 1'b1);
            check("R8", "usr idle w/o fetch", usr, 1'b1);
        end
        if (!f && !r && !w) begin
            check("R9", "all high", mon & usr & rce & roe & rwe & pce & prd & pwr, 1'b1);
        end
        if (!in_ram) check("R10", "ram off-block", rce & roe & rwe, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        addr_hi = 3'd0;
        fetch_n = 1'b1;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle state after reset (R9)
        check("R9", "idle mon", a_mon, 1'b1);
        check("R9", "idle ram_ce", a_rce, 1'b1);
        check("R9", "idle per_ce", a_pce, 1'b1);
        // Full sweep: R1 block numbering, combinational response
        for (int blk = 0; blk < 8; blk++) begin
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                addr_hi = 3'(blk);
                fetch_n = s[2];
                rd_n    = s[1];
                wr_n    = s[0];
                #1;
                check("R1", "no latency", a_mon, !(blk == 0 && !s[2]));
                check_inst(4, a_mon, a_usr, a_rce, a_roe, a_rwe, a_pce, a_prd, a_pwr);
                check_inst(6, b_mon, b_usr, b_rce, b_roe, b_rwe, b_pce, b_prd, b_pwr);
            end
        end
        // Relocation corner: block 4 empty in the alternate placement (R10)
        @(negedge clk);
        addr_hi = 3'd4; fetch_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        #1;
        check("R10", "alt ram absent at 4", b_rce, 1'b1);
        check("R10", "default ram at 4", a_rce, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule